// File: doc/BRIEF.md
# System Exception Pending-Control Register

This block is one 32-bit memory-mapped control and status word. It holds the pending state of three system exceptions: the non-maskable interrupt (NMI), a deferred supervisor-call exception raised only by software, and a periodic-timer exception. Software sets each pending flag by writing a one to its set bit. The supervisor-call and timer flags also have a separate clear bit. A write of zero to any bit does nothing.

The exception core acknowledges entry with a one-cycle pulse and an exception identifier. That pulse clears the matching flag. A flag read back from inside the handler therefore shows only an event that arrived after entry. Two hardware events also set flags: a rising edge on the NMI line and the timer wrap pulse. Either event wins over an entry acknowledge in the same cycle, so the event is never lost.

The same word also carries three read-only status values driven by the exception core:
- whether any interrupt is pending,
- the number of the highest-priority pending exception,
- whether preempted active exceptions exist.

The three pending flags are also driven out to the exception core.

Top module: `exc_pend_ctrl`

## Requirements
- R1: After reset all three pending flags are 0 and the pending outputs are low.
- R2: A register write with bit 31 set makes NMI pending. Bit 31 reads the NMI pending state. Zero bits in any write leave all flags unchanged.
- R3: A rising edge of `nmi_line_i` makes NMI pending. An entry acknowledge with identifier 2 clears it. When both occur in the same cycle, the flag ends up set.
- R4: Writing 1 to bit 28 makes the supervisor-call exception pending. Bit 28 reads its state. Nothing other than such a write sets this flag.
- R5: Writing 1 to bit 27 clears the supervisor-call flag. Bit 27 always reads 0. A write with both bit 28 and bit 27 set leaves the flag clear.
- R6: Bit 26 sets the timer flag and bit 25 clears it. Bit 25 reads 0, bit 26 reads the timer state, and a write with both bits set leaves the flag clear.
- R7: A `tick_wrap_i` pulse makes the timer flag pending. It wins over an entry acknowledge with identifier 15 in the same cycle.
- R8: An entry acknowledge clears only the flag whose identifier matches: 2 for NMI, 14 for supervisor call, 15 for timer. Any other identifier clears nothing.
- R9: Three status fields are read-only and follow the core inputs: bit 22 shows `core_irq_pend_i`, bits 20:12 show `core_vec_i`, and bit 11 shows `core_preempt_i`.
- R10: Reserved bits read 0 and ignore writes. `reg_rdata_o` is all zero while `reg_sel_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Address match for this register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, zero when not selected |
| ack_valid_i | input | 1 | One-cycle exception entry acknowledge |
| ack_id_i | input | 9 | Identifier of the exception being entered |
| nmi_line_i | input | 1 | NMI request line, edge sensitive |
| tick_wrap_i | input | 1 | Timer wrap pulse |
| core_vec_i | input | 9 | Highest-priority pending exception number |
| core_irq_pend_i | input | 1 | Any interrupt pending |
| core_preempt_i | input | 1 | Preempted active exceptions exist |
| nmi_pend_o | output | 1 | NMI pending flag |
| svc_pend_o | output | 1 | Supervisor-call pending flag |
| tick_pend_o | output | 1 | Timer pending flag |

## Verification
The assertions check on every cycle:
- a set write or a timer pulse produces a pending flag on the next cycle,
- a clear bit always beats its set bit,
- the supervisor-call flag never rises without a software write,
- the reserved and write-only positions read zero,
- the interrupt-pending status bit follows its input.

Only the bench scenarios show the rest:
- that the NMI edge detector ignores a held-high line,
- that an acknowledge clears exactly the matching flag and leaves the others intact,
- that an unknown identifier changes nothing,
- that the full read word, status fields included, matches the expected pattern after each sequence.

// File: rtl/exc_pend_pkg.sv
package exc_pend_pkg;

    // Flag slots; the order is fixed because every table below uses it.
    localparam int NUM_EXC  = 3;
    localparam int SLOT_NMI = 0;
    localparam int SLOT_SVC = 1;
    localparam int SLOT_TCK = 2;

    // Status field placement in the read word.
    localparam int IRQ_POS = 22;
    localparam int VEC_LSB = 12;
    localparam int PRE_POS = 11;

    typedef struct packed {
        logic [NUM_EXC-1:0] pend;
        logic               line_prev;
    } pend_state_t;

    function automatic int set_pos(input int slot);
        case (slot)
            SLOT_NMI: return 31;
            SLOT_SVC: return 28;
            default:  return 26;
        endcase
    endfunction

    function automatic bit has_clr(input int slot);
        return slot != SLOT_NMI;
    endfunction

    function automatic int clr_pos(input int slot);
        case (slot)
            SLOT_SVC: return 27;
            SLOT_TCK: return 25;
            default:  return 0;
        endcase
    endfunction

    function automatic int exc_id(input int slot);
        case (slot)
            SLOT_NMI: return 2;
            SLOT_SVC: return 14;
            default:  return 15;
        endcase
    endfunction

endpackage

// File: rtl/exc_pend_wrdec.sv
module exc_pend_wrdec
    import exc_pend_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [NUM_EXC-1:0] sw_set_o,
    output logic [NUM_EXC-1:0] sw_clr_o
);

    logic wdata_unused;
    assign wdata_unused = ^wdata_i;

    for (genvar g = 0; g < NUM_EXC; g++) begin : g_slot
        localparam int SP = set_pos(g);
        assign sw_set_o[g] = wr_en_i & wdata_i[SP];
        if (has_clr(g)) begin : g_clr
            localparam int CP = clr_pos(g);
            assign sw_clr_o[g] = wr_en_i & wdata_i[CP];
        end else begin : g_noclr
            assign sw_clr_o[g] = 1'b0;
        end
    end

endmodule

// File: rtl/exc_pend_next.sv
module exc_pend_next
    import exc_pend_pkg::*;
#(
    parameter int ID_W = 9
) (
    input  logic [NUM_EXC-1:0] pend_q_i,
    input  logic [NUM_EXC-1:0] sw_set_i,
    input  logic [NUM_EXC-1:0] sw_clr_i,
    input  logic [NUM_EXC-1:0] hw_set_i,
    input  logic               ack_valid_i,
    input  logic [ID_W-1:0]    ack_id_i,
    output logic [NUM_EXC-1:0] pend_d_o
);

    for (genvar g = 0; g < NUM_EXC; g++) begin : g_slot
        localparam logic [ID_W-1:0] EID = ID_W'(exc_id(g));
        logic ack_hit;
        assign ack_hit = ack_valid_i && (ack_id_i == EID);
        // Hardware events beat every clear; software clear beats software set.
        assign pend_d_o[g] = hw_set_i[g]
                           | (sw_set_i[g] & ~sw_clr_i[g])
                           | (pend_q_i[g] & ~sw_clr_i[g] & ~ack_hit);
    end

endmodule

// File: rtl/exc_pend_rdmux.sv
module exc_pend_rdmux
    import exc_pend_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int VEC_W  = 9
) (
    input  logic               sel_i,
    input  logic [NUM_EXC-1:0] pend_i,
    input  logic               irq_pend_i,
    input  logic [VEC_W-1:0]   vec_i,
    input  logic               preempt_i,
    output logic [DATA_W-1:0]  rdata_o
);

    logic [DATA_W-1:0] word;

    always_comb begin
        word = '0;
        for (int s = 0; s < NUM_EXC; s++) begin
            word[set_pos(s)] = pend_i[s];
        end
        word[IRQ_POS]                 = irq_pend_i;
        word[VEC_LSB +: VEC_W]        = vec_i;
        word[PRE_POS]                 = preempt_i;
        rdata_o = sel_i ? word : '0;
    end

endmodule

// File: rtl/exc_pend_ctrl.sv
module exc_pend_ctrl
    import exc_pend_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ID_W   = 9,
    parameter int VEC_W  = 9
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_wr_i,
    input  logic              reg_sel_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic              ack_valid_i,
    input  logic [ID_W-1:0]   ack_id_i,
    input  logic              nmi_line_i,
    input  logic              tick_wrap_i,
    input  logic [VEC_W-1:0]  core_vec_i,
    input  logic              core_irq_pend_i,
    input  logic              core_preempt_i,
    output logic              nmi_pend_o,
    output logic              svc_pend_o,
    output logic              tick_pend_o
);

    pend_state_t st_q, st_d;

    logic [NUM_EXC-1:0] sw_set, sw_clr, hw_set, pend_nx;

    exc_pend_wrdec #(.DATA_W(DATA_W)) u_wrdec (
        .wr_en_i  (reg_wr_i & reg_sel_i),
        .wdata_i  (reg_wdata_i),
        .sw_set_o (sw_set),
        .sw_clr_o (sw_clr)
    );

    always_comb begin
        hw_set           = '0;
        hw_set[SLOT_NMI] = nmi_line_i & ~st_q.line_prev;
        hw_set[SLOT_TCK] = tick_wrap_i;
    end

    exc_pend_next #(.ID_W(ID_W)) u_next (
        .pend_q_i    (st_q.pend),
        .sw_set_i    (sw_set),
        .sw_clr_i    (sw_clr),
        .hw_set_i    (hw_set),
        .ack_valid_i (ack_valid_i),
        .ack_id_i    (ack_id_i),
        .pend_d_o    (pend_nx)
    );

    always_comb begin
        st_d           = st_q;
        st_d.pend      = pend_nx;
        st_d.line_prev = nmi_line_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    exc_pend_rdmux #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_rdmux (
        .sel_i      (reg_sel_i),
        .pend_i     (st_q.pend),
        .irq_pend_i (core_irq_pend_i),
        .vec_i      (core_vec_i),
        .preempt_i  (core_preempt_i),
        .rdata_o    (reg_rdata_o)
    );

    assign nmi_pend_o  = st_q.pend[SLOT_NMI];
    assign svc_pend_o  = st_q.pend[SLOT_SVC];
    assign tick_pend_o = st_q.pend[SLOT_TCK];

endmodule

// File: rtl/exc_pend_ctrl_chk.sv
module exc_pend_ctrl_chk #(
    parameter int DATA_W = 32,
    parameter int ID_W   = 9
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              reg_wr_i,
    input logic              reg_sel_i,
    input logic [DATA_W-1:0] reg_wdata_i,
    input logic [DATA_W-1:0] reg_rdata_o,
    input logic              ack_valid_i,
    input logic [ID_W-1:0]   ack_id_i,
    input logic              tick_wrap_i,
    input logic              core_irq_pend_i,
    input logic              nmi_pend_o,
    input logic              svc_pend_o,
    input logic              tick_pend_o
);

    logic wen;
    assign wen = reg_wr_i & reg_sel_i;

    AST_NMI_SW_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wen && reg_wdata_i[31] |=> nmi_pend_o); // R2

    AST_SVC_SW_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wen && reg_wdata_i[28] && !reg_wdata_i[27] |=> svc_pend_o); // R4

    AST_SVC_SW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !svc_pend_o && !(wen && reg_wdata_i[28]) |=> !svc_pend_o); // R4

    AST_SVC_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wen && reg_wdata_i[27] |=> !svc_pend_o); // R5

    AST_TICK_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wen && reg_wdata_i[25] && !tick_wrap_i |=> !tick_pend_o); // R6

    AST_TICK_WRAP_PENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_wrap_i |=> tick_pend_o); // R7

    AST_SVC_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_valid_i && ack_id_i == ID_W'(14) && !(wen && reg_wdata_i[28]) |=> !svc_pend_o); // R8

    AST_IRQ_STATUS_SHOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_sel_i |-> reg_rdata_o[22] == core_irq_pend_i); // R9

    AST_RSVD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_sel_i |-> reg_rdata_o[30:29] == 2'b00 && reg_rdata_o[27] == 1'b0 && reg_rdata_o[25] == 1'b0); // R10

    AST_UNSEL_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !reg_sel_i |-> reg_rdata_o == '0); // R10

endmodule

bind exc_pend_ctrl exc_pend_ctrl_chk #(.DATA_W(DATA_W), .ID_W(ID_W)) u_chk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .reg_wr_i        (reg_wr_i),
    .reg_sel_i       (reg_sel_i),
    .reg_wdata_i     (reg_wdata_i),
    .reg_rdata_o     (reg_rdata_o),
    .ack_valid_i     (ack_valid_i),
    .ack_id_i        (ack_id_i),
    .tick_wrap_i     (tick_wrap_i),
    .core_irq_pend_i (core_irq_pend_i),
    .nmi_pend_o      (nmi_pend_o),
    .svc_pend_o      (svc_pend_o),
    .tick_pend_o     (tick_pend_o)
);

// File: tb/exc_pend_ctrl_tb_top.sv
`timescale 1ns/1ps
module exc_pend_ctrl_tb_top;

    localparam int DATA_W = 32;
    localparam int ID_W   = 9;
    localparam int VEC_W  = 9;

    logic              clk = 1'b0;
    logic              rst_ni = 1'b0;
    logic              reg_wr = 1'b0;
    logic              reg_sel = 1'b0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              ack_valid = 1'b0;
    logic [ID_W-1:0]   ack_id = '0;
    logic              nmi_line = 1'b0;
    logic              tick_wrap = 1'b0;
    logic [VEC_W-1:0]  core_vec = '0;
    logic              core_irq = 1'b0;
    logic              core_pre = 1'b0;
    logic              nmi_pend, svc_pend, tick_pend;

    always #4 clk = ~clk;

    exc_pend_ctrl #(.DATA_W(DATA_W), .ID_W(ID_W), .VEC_W(VEC_W)) dut_i (
        .clk_i           (clk),
        .rst_ni          (rst_ni),
        .reg_wr_i        (reg_wr),
        .reg_sel_i       (reg_sel),
        .reg_wdata_i     (reg_wdata),
        .reg_rdata_o     (reg_rdata),
        .ack_valid_i     (ack_valid),
        .ack_id_i        (ack_id),
        .nmi_line_i      (nmi_line),
        .tick_wrap_i     (tick_wrap),
        .core_vec_i      (core_vec),
        .core_irq_pend_i (core_irq),
        .core_preempt_i  (core_pre),
        .nmi_pend_o      (nmi_pend),
        .svc_pend_o      (svc_pend),
        .tick_pend_o     (tick_pend)
    );

    typedef struct {
        logic [DATA_W-1:0] word;
        string             tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    function automatic logic [31:0] mk_word(input bit n, input bit s, input bit t,
                                             input bit irq, input logic [8:0] vec, input bit pre);
        logic [31:0] w;
        w = '0;
        w[31] = n; w[28] = s; w[26] = t;
        w[22] = irq; w[20:12] = vec; w[11] = pre;
        return w;
    endfunction

    // Monitor: pops expected items and compares read word and flag outputs.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_item_t it;
                it = exp_q.pop_front();
                n_checks++;
                if (reg_rdata !== it.word ||
                    nmi_pend !== it.word[31] || svc_pend !== it.word[28] ||
                    tick_pend !== it.word[26]) begin
                    n_fails++;
                    $display("FAIL %s: rdata=%h flags=%b%b%b expected rdata=%h flags=%b%b%b",
                             it.tag, reg_rdata, nmi_pend, svc_pend, tick_pend,
                             it.word, it.word[31], it.word[28], it.word[26]);
                end
            end
        end
    end

    task automatic do_write(input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    endtask

    task automatic do_ack(input int id);
        @(negedge clk);
        ack_valid = 1'b1; ack_id = ID_W'(id);
        @(negedge clk);
        ack_valid = 1'b0; ack_id = '0;
    endtask

    task automatic expect_read(input logic [31:0] w, input string tag);
        exp_item_t it;
        @(negedge clk);
        reg_sel = 1'b1;
        it.word = w; it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk);
        reg_sel = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;

        expect_read(mk_word(0,0,0,0,0,0), "R1 reset state");
        do_write(32'h0000_0000);
        expect_read(mk_word(0,0,0,0,0,0), "R2 zero write no effect");

        do_write(32'h8000_0000);
        expect_read(mk_word(1,0,0,0,0,0), "R2 NMI set by write");
        do_ack(2);
        expect_read(mk_word(0,0,0,0,0,0), "R3 NMI cleared by entry");

        @(negedge clk) nmi_line = 1'b1;
        expect_read(mk_word(1,0,0,0,0,0), "R3 NMI edge pends");
        do_ack(2);
        expect_read(mk_word(0,0,0,0,0,0), "R3 held line does not re-pend");
        @(negedge clk) nmi_line = 1'b0;
        @(negedge clk);
        nmi_line = 1'b1; ack_valid = 1'b1; ack_id = ID_W'(2);
        @(negedge clk);
        ack_valid = 1'b0; ack_id = '0;
        expect_read(mk_word(1,0,0,0,0,0), "R3 edge wins over entry");
        nmi_line = 1'b0;
        do_ack(2);

        do_write(32'h1000_0000);
        expect_read(mk_word(0,1,0,0,0,0), "R4 svc set by write");
        do_write(32'h0800_0000);
        expect_read(mk_word(0,0,0,0,0,0), "R5 svc clear");
        do_write(32'h1800_0000);
        expect_read(mk_word(0,0,0,0,0,0), "R5 clear wins over set");

        do_write(32'h0400_0000);
        expect_read(mk_word(0,0,1,0,0,0), "R6 tick set by write");
        do_write(32'h0200_0000);
        expect_read(mk_word(0,0,0,0,0,0), "R6 tick clear");
        do_write(32'h0600_0000);
        expect_read(mk_word(0,0,0,0,0,0), "R6 clear wins over set");

        @(negedge clk) tick_wrap = 1'b1;
        @(negedge clk) tick_wrap = 1'b0;
        expect_read(mk_word(0,0,1,0,0,0), "R7 wrap pulse pends");
        @(negedge clk);
        tick_wrap = 1'b1; ack_valid = 1'b1; ack_id = ID_W'(15);
        @(negedge clk);
        tick_wrap = 1'b0; ack_valid = 1'b0; ack_id = '0;
        expect_read(mk_word(0,0,1,0,0,0), "R7 wrap wins over entry");

        do_write(32'h9400_0000);
        expect_read(mk_word(1,1,1,0,0,0), "R8 all set, svc never set by hardware R4");
        do_ack(14);
        expect_read(mk_word(1,0,1,0,0,0), "R8 id 14 clears only svc");
        do_ack(5);
        expect_read(mk_word(1,0,1,0,0,0), "R8 unknown id clears nothing");
        do_ack(15);
        expect_read(mk_word(1,0,0,0,0,0), "R8 id 15 clears only tick");
        do_ack(2);
        expect_read(mk_word(0,0,0,0,0,0), "R8 id 2 clears NMI");

        core_irq = 1'b1; core_vec = 9'h1A5; core_pre = 1'b1;
        expect_read(mk_word(0,0,0,1,9'h1A5,1), "R9 status fields shown");
        do_write(32'hFFFF_FFFF);
        expect_read(mk_word(1,0,0,1,9'h1A5,1), "R10 all-ones write: reserved and status ignored");
        core_irq = 1'b0; core_vec = 9'h04A; core_pre = 1'b0;
        expect_read(mk_word(1,0,0,0,9'h04A,0), "R9 status follows inputs");

        @(negedge clk);
        #2;
        n_checks++;
        if (reg_rdata !== '0) begin
            n_fails++;
            $display("FAIL R10 unselected read: rdata=%h expected=%h", reg_rdata, 32'h0);
        end

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule